// File: doc/BRIEF.md
# Staged Holding Register with Cascadable Binary Up-Counter

This block pairs an eight-bit holding register with an eight-bit binary up-counter. The holding register samples a parallel data byte on the rising edge of its own clock. The counter runs on a second, independent clock. Software or surrounding logic first stages a preset value in the holding register. It then copies that value into the counter with a direct, unclocked load. The counter can also be zeroed at any moment by a direct clear.

Counting is gated by an active-low enable. The counter produces an active-low ripple carry, a purely combinational decode that goes low while the counter is all ones and the enable is active. Because the carry has the same polarity as the enable, a wider counter is built by wiring one stage's carry into the next stage's enable, with every stage on the same counter clock. The counter value is brought out for observation and test.

Top module: `staged_counter`

## Requirements
- R1: On each rising edge of `rck` the holding register captures `din`. Between those edges it keeps its value even if `din` changes.
- R2: While `clr_n` and `load_n` are high, a rising edge of `cck` with `cnt_en_n` low adds one to `cnt_q`.
- R3: While `clr_n` and `load_n` are high, a rising edge of `cck` with `cnt_en_n` high leaves `cnt_q` unchanged.
- R4: While `clr_n` is low, `cnt_q` is 0 immediately, with no clock edge needed. This holds whatever `load_n`, `cnt_en_n`, `rck` or `cck` do.
- R5: When `load_n` goes low with `clr_n` high, `cnt_q` takes the holding register's contents immediately, with no `cck` edge. While `load_n` stays low, `cck` edges do not count.
- R6: Capturing a new byte into the holding register does not change `cnt_q` unless a load follows.
- R7: `rco_n` is 0 exactly when all bits of `cnt_q` are 1 and `cnt_en_n` is 0; otherwise it is 1. It follows `cnt_en_n` with no clock edge.
- R8: An enabled count from 255 gives 0.
- R9: When two stages share `cck`, `clr_n` and `load_n`, and the upper stage's `cnt_en_n` is driven by the lower stage's `rco_n`, the upper stage advances by one exactly on the edges where the lower stage wraps from 255 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rck | input | 1 | Holding register clock, rising edge |
| cck | input | 1 | Counter clock, rising edge |
| clr_n | input | 1 | Direct counter clear, active low, highest priority |
| load_n | input | 1 | Direct load of the holding register into the counter, active low |
| cnt_en_n | input | 1 | Count enable, active low |
| din | input | WIDTH (8) | Parallel data byte for the holding register |
| rco_n | output | 1 | Ripple carry, active low, combinational |
| cnt_q | output | WIDTH (8) | Counter value |

## Verification
The bench runs a two-stage cascade. It tries the counter with random mixes of register captures, direct loads, clears, simultaneous clear and load, and clock edges whose enable is random. This separates counting from holding, and it shows whether clear wins over load. Directed loads of 254 and 255, followed by enabled and disabled edges, show whether the wrap to zero, the carry decode and its reaction to the enable without a clock are correct. They also show whether the upper stage advances only on lower-stage wraps. Changing `din` without an `rck` edge, and capturing a byte without loading it, show whether the holding register is truly separate from the counter.

// File: rtl/staged_counter.sv
module staged_counter #(
  parameter int WIDTH = 8
) (
  input  logic             rck,
  input  logic             cck,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic [WIDTH-1:0] din,
  output logic             rco_n,
  output logic [WIDTH-1:0] cnt_q
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] hold_q;

  always_ff @(posedge rck)
    hold_q <= din;

  always_ff @(posedge cck or negedge clr_n or negedge load_n)
    if (!clr_n)         cnt_q <= '0;
    else if (!load_n)   cnt_q <= hold_q;
    else if (!cnt_en_n) cnt_q <= cnt_q + 1'b1;

  assign rco_n = ~((cnt_q == ALL_ONES) & ~cnt_en_n);

  // R2
  count_step_chk: assert property (@(posedge cck) disable iff (!clr_n || !load_n)
    !cnt_en_n |=> cnt_q == $past(cnt_q) + 1'b1);

  // R3
  count_hold_chk: assert property (@(posedge cck) disable iff (!clr_n || !load_n)
    cnt_en_n |=> $stable(cnt_q));

  // R8
  wrap_zero_chk: assert property (@(posedge cck) disable iff (!clr_n || !load_n)
    !rco_n |=> cnt_q == '0);

  // R4
  always_ff @(posedge cck)
    if (!clr_n) clear_zero_chk: assert (cnt_q == '0);

  // R5
  always_ff @(posedge rck)
    if (clr_n && !load_n) load_match_chk: assert (cnt_q == hold_q);

endmodule

// File: tb/tb_staged_counter.sv
module tb_staged_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic rck = 0, cck = 0, clr_n = 0, load_n = 1, en_n = 1;
  logic [W-1:0] din_lo = 0, din_hi = 0;
  logic rco_lo, rco_hi;
  logic [W-1:0] q_lo, q_hi;

  staged_counter #(.WIDTH(W)) dut (
    .rck(rck), .cck(cck), .clr_n(clr_n), .load_n(load_n), .cnt_en_n(en_n),
    .din(din_lo), .rco_n(rco_lo), .cnt_q(q_lo));

  staged_counter #(.WIDTH(W)) dut_hi (
    .rck(rck), .cck(cck), .clr_n(clr_n), .load_n(load_n), .cnt_en_n(rco_lo),
    .din(din_hi), .rco_n(rco_hi), .cnt_q(q_hi));

  int checks = 0, fails = 0;
  logic [W-1:0] m_hold_lo, m_hold_hi, m_lo, m_hi;

  function automatic logic exp_rco_lo(logic [W-1:0] lo, logic en);
    return !(lo == 8'hFF && !en);
  endfunction

  function automatic logic exp_rco_hi(logic [W-1:0] lo, logic [W-1:0] hi, logic en);
    return !(hi == 8'hFF && !exp_rco_lo(lo, en));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, 32'(q_lo), 32'(m_lo));
    chk(req, 32'(q_hi), 32'(m_hi));
    chk({req, " rco"}, 32'(rco_lo), 32'(exp_rco_lo(m_lo, en_n)));
    chk({req, " rco_hi"}, 32'(rco_hi), 32'(exp_rco_hi(m_lo, m_hi, en_n)));
  endtask

  task automatic store(logic [W-1:0] lo, logic [W-1:0] hi);
    din_lo = lo; din_hi = hi;
    #1 rck = 1; #1 rck = 0; #1;
    m_hold_lo = lo; m_hold_hi = hi;
  endtask

  task automatic tick(logic en);
    logic carry;
    en_n = en;
    #1;
    #(CLK_PERIOD/2) cck = 1;
    carry = (m_lo == 8'hFF) && !en;
    if (!clr_n) begin m_lo = 0; m_hi = 0; end
    else if (!load_n) begin m_lo = m_hold_lo; m_hi = m_hold_hi; end
    else begin
      if (!en) m_lo = m_lo + 1'b1;
      if (carry) m_hi = m_hi + 1'b1;
    end
    #(CLK_PERIOD/2) cck = 0;
  endtask

  task automatic do_load(string req);
    load_n = 0; #1;
    m_lo = m_hold_lo; m_hi = m_hold_hi;
    chk_all(req);
    tick(en_n);
    chk_all(req);
    load_n = 1; #1;
  endtask

  task automatic do_clear(string req);
    clr_n = 0; #1;
    m_lo = 0; m_hi = 0;
    chk_all(req);
    tick(1'b0);
    chk_all(req);
    clr_n = 1; #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20417));
    m_lo = 0; m_hi = 0;
    #3;
    chk_all("R4 reset");
    store(8'h11, 8'h22);
    clr_n = 1; #1;
    chk_all("R4 reset held");

    // R1: capture, then din change without edge is ignored
    store(8'h3C, 8'h5A);
    din_lo = 8'hC3; din_hi = 8'hA5; #2;
    do_load("R1 capture");

    // R6: new capture does not disturb counter
    store(8'h77, 8'h01);
    chk_all("R6 no transfer");

    // R2 / R3
    tick(1'b0); chk_all("R2 count");
    tick(1'b1); chk_all("R3 hold");

    // R4 / R5 priority: clear and load both low
    load_n = 0; do_clear("R4 clear over load"); load_n = 1; #1;
    chk_all("R4 after release");

    // R5 direct load with clock idle, counting blocked while held
    store(8'hFE, 8'h00);
    do_load("R5 load");

    // R7 combinational carry, R8 wrap, R9 cascade
    tick(1'b0); chk_all("R7 at FF");
    chk(  "R7 rco low", 32'(rco_lo), 32'd0);
    en_n = 1; #1; chk("R7 enable off", 32'(rco_lo), 32'd1);
    en_n = 0; #1; chk("R7 enable on", 32'(rco_lo), 32'd0);
    tick(1'b0); chk_all("R8 wrap");
    chk("R8 lo zero", 32'(q_lo), 32'd0);
    chk("R9 hi step", 32'(q_hi), 32'd1);
    store(8'hFF, 8'hFF);
    do_load("R9 load ones");
    tick(1'b1); chk_all("R9 disabled no carry");
    tick(1'b0); chk_all("R9 double wrap");

    for (int i = 0; i < 600; i++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0: store(W'($urandom), W'($urandom));
        1: do_load("R5 random load");
        2: do_clear("R4 random clear");
        3: begin load_n = 0; do_clear("R4 random clear+load"); load_n = 1; #1; end
        4: begin store(8'hFD + W'($urandom % 3), W'($urandom % 2 ? 8'hFF : 8'h10));
                 do_load("R9 near wrap"); end
        default: begin tick(logic'($urandom % 4 == 0)); chk_all("R2 R3 R9 random"); end
      endcase
    end
    finish_run();
  end
endmodule